// File: doc/BRIEF.md
# Banked Data Address Generator

This block produces the 12-bit data-memory address for a small 8-bit core whose 4096-byte register file is organised as sixteen 256-byte banks. A direct-addressing instruction carries only an 8-bit file offset. The two low bits of the opcode byte choose how that offset is widened: bit 0 picks either the split access bank or the bank held in the bank select register, and bit 1 is the destination bit (file or working register). The block decodes both bits and outputs them.

The access bank joins the lower 128 bytes of bank 0 with the upper 128 bytes of bank 15, where the special-function registers sit. The bank select register can be loaded from an instruction literal or from the data bus. Only its low four bits take part in addressing. A two-word register-to-register move bypasses all of this and drives a full 12-bit source or destination address. A flag marks every address that falls in the special-function region.

Top module: `bank_addr_gen`

## Requirements
- R1: After reset the bank select register reads 0, so a banked access (opcode bit 0 = 1) with offset k resolves to address k.
- R2: With opcode bit 0 = 0 and offset 0x00–0x7F, the address is 0x000 plus the offset.
- R3: With opcode bit 0 = 0 and offset 0x80–0xFF, the address is 0xF00 plus the offset (0xF80–0xFFF).
- R4: With opcode bit 0 = 1, address bits 11:8 equal bank register bits 3:0 and address bits 7:0 equal the offset.
- R5: A literal load (bank_lit_we_i) stores bank_lit_i on the clock edge. The new bank is used from the next cycle, and with no write strobe the bank holds.
- R6: A bus write (bank_bus_we_i) stores bank_bus_i on the clock edge, used from the next cycle.
- R7: When both write strobes are high in one cycle, the literal value is stored.
- R8: bank_rd_o returns bank bits 3:0 with bits 7:4 read as zero, and written bits 7:4 have no effect on any address.
- R9: While mov_en_i is high, addr_o equals mov_src_i when mov_dst_sel_i = 0 and mov_dst_i when it is 1. The bank register and access bit are ignored.
- R10: sfr_o is 1 exactly when addr_o is 0xF80 or above, in every mode.
- R11: dest_f_o equals opcode bit 1 and access_o equals opcode bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_lo_i | input | 2 | Low opcode bits: [1] destination, [0] access select |
| offset_i | input | 8 | Direct file offset from the instruction |
| bank_lit_we_i | input | 1 | Load bank register from literal |
| bank_lit_i | input | 8 | Literal bank value |
| bank_bus_we_i | input | 1 | Write bank register from data bus |
| bank_bus_i | input | 8 | Bus write data |
| bank_rd_o | output | 8 | Bank register readback |
| mov_en_i | input | 1 | Two-word move in progress |
| mov_dst_sel_i | input | 1 | 0: source phase, 1: destination phase |
| mov_src_i | input | 12 | Full move source address |
| mov_dst_i | input | 12 | Full move destination address |
| addr_o | output | 12 | Resolved data address |
| sfr_o | output | 1 | Address lies in special-function region |
| dest_f_o | output | 1 | Decoded destination bit |
| access_o | output | 1 | Decoded access select bit |

## Verification
The hardest situation to reach is the collision of both bank write strobes in one cycle, combined with upper-nibble garbage in the written values. Only the following cycle's banked address and readback show which write won. The random stimulus raises each strobe independently with high probability, so collisions occur often. It always fills bits 7:4 with random data. Directed steps then cover the access-bank halves at 0x7F/0x80, bank 15 offset 0x7F/0x80 on both sides of the special-region boundary, and move addresses of 0xF7F and 0xF80.

// File: rtl/bag_pkg.sv
package bag_pkg;
  localparam int ADDR_W   = 12;
  localparam int OFF_W    = 8;
  localparam int BANK_W   = 8;
  localparam int SEL_W    = ADDR_W - OFF_W;
  localparam int SFR_SPAN = 1 << (OFF_W - 1);

  typedef struct packed {
    logic dest_f;
    logic banked;
  } op_ctl_t;
endpackage

// File: rtl/bag_opdec.sv
module bag_opdec
  import bag_pkg::*;
(
  input  logic [1:0] op_lo_i,
  output op_ctl_t    ctl_o
);
  // bit1 = destination, bit0 = access select
  always_comb begin
    ctl_o.dest_f = op_lo_i[1];
    ctl_o.banked = op_lo_i[0];
  end
endmodule

// File: rtl/bag_bank_reg.sv
module bag_bank_reg #(
  parameter int BANK_W = 8,
  parameter int SEL_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lit_we_i,
  input  logic [BANK_W-1:0] lit_i,
  input  logic              bus_we_i,
  input  logic [BANK_W-1:0] bus_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic [BANK_W-1:0] rd_o
);
  logic [BANK_W-1:0] bank_q;

  // literal load has priority over a bus write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bank_q <= '0;
    else if (lit_we_i) bank_q <= lit_i;
    else if (bus_we_i) bank_q <= bus_i;
  end

  assign sel_o = bank_q[SEL_W-1:0];
  assign rd_o  = {{(BANK_W-SEL_W){1'b0}}, bank_q[SEL_W-1:0]};

  logic unused_hi;
  assign unused_hi = ^bank_q[BANK_W-1:SEL_W];

  AST_LIT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lit_we_i |=> sel_o == $past(lit_i[SEL_W-1:0])); // R7
  AST_BUS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && !lit_we_i) |=> sel_o == $past(bus_i[SEL_W-1:0])); // R6
  AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_we_i && !lit_we_i) |=> $stable(sel_o)); // R5
endmodule

// File: rtl/bag_access_map.sv
module bag_access_map #(
  parameter int OFF_W = 8,
  parameter int SEL_W = 4,
  parameter bit SPLIT = 1'b1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [OFF_W-1:0]       off_i,
  input  logic                   banked_i,
  input  logic [SEL_W-1:0]       bank_sel_i,
  output logic [SEL_W+OFF_W-1:0] addr_o,
  output logic                   sfr_o
);
  localparam int ADDR_W = SEL_W + OFF_W;
  logic [SEL_W-1:0] acc_page;
  logic             acc_sfr;

  generate
    if (SPLIT) begin : g_split
      // upper half of offset space maps to the last page
      assign acc_page = {SEL_W{off_i[OFF_W-1]}};
      assign acc_sfr  = off_i[OFF_W-1];
    end else begin : g_flat
      assign acc_page = '0;
      assign acc_sfr  = 1'b0;
    end
  endgenerate

  always_comb begin
    if (banked_i) begin
      addr_o = {bank_sel_i, off_i};
      sfr_o  = (&bank_sel_i) & off_i[OFF_W-1];
    end else begin
      addr_o = {acc_page, off_i};
      sfr_o  = acc_sfr;
    end
  end

  AST_ACC_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!banked_i && !off_i[OFF_W-1]) |-> addr_o[ADDR_W-1:OFF_W] == '0); // R2
  AST_ACC_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!banked_i && off_i[OFF_W-1] && SPLIT) |-> (&addr_o[ADDR_W-1:OFF_W])); // R3
  AST_BANKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    banked_i |-> (addr_o[ADDR_W-1:OFF_W] == bank_sel_i && addr_o[OFF_W-1:0] == off_i)); // R4
endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen
  import bag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        op_lo_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic              bank_lit_we_i,
  input  logic [BANK_W-1:0] bank_lit_i,
  input  logic              bank_bus_we_i,
  input  logic [BANK_W-1:0] bank_bus_i,
  output logic [BANK_W-1:0] bank_rd_o,
  input  logic              mov_en_i,
  input  logic              mov_dst_sel_i,
  input  logic [ADDR_W-1:0] mov_src_i,
  input  logic [ADDR_W-1:0] mov_dst_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sfr_o,
  output logic              dest_f_o,
  output logic              access_o
);
  localparam logic [ADDR_W-1:0] SFR_BASE = ADDR_W'((1 << ADDR_W) - SFR_SPAN);

  op_ctl_t           ctl;
  logic [SEL_W-1:0]  bank_sel;
  logic [ADDR_W-1:0] dir_addr, mov_addr;
  logic              dir_sfr;

  bag_opdec u_opdec (.op_lo_i(op_lo_i), .ctl_o(ctl));

  bag_bank_reg #(.BANK_W(BANK_W), .SEL_W(SEL_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lit_we_i(bank_lit_we_i), .lit_i(bank_lit_i),
    .bus_we_i(bank_bus_we_i), .bus_i(bank_bus_i),
    .sel_o(bank_sel), .rd_o(bank_rd_o)
  );

  bag_access_map #(.OFF_W(OFF_W), .SEL_W(SEL_W), .SPLIT(1'b1)) u_map (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .off_i(offset_i), .banked_i(ctl.banked), .bank_sel_i(bank_sel),
    .addr_o(dir_addr), .sfr_o(dir_sfr)
  );

  assign mov_addr = mov_dst_sel_i ? mov_dst_i : mov_src_i;
  assign addr_o   = mov_en_i ? mov_addr : dir_addr;
  assign sfr_o    = mov_en_i ? (&mov_addr[ADDR_W-1:OFF_W-1]) : dir_sfr;
  assign dest_f_o = ctl.dest_f;
  assign access_o = ctl.banked;

  AST_MOVE_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mov_en_i |-> addr_o == (mov_dst_sel_i ? mov_dst_i : mov_src_i)); // R9
  AST_SFR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfr_o == (addr_o >= SFR_BASE)); // R10
  AST_RD_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_rd_o[BANK_W-1:SEL_W] == '0); // R8
endmodule

// File: tb/bank_addr_gen_tb.sv
module bank_addr_gen_tb;
  logic        clk_i = 0, rst_ni = 0;
  logic [1:0]  op_lo_i = 0;
  logic [7:0]  offset_i = 0, bank_lit_i = 0, bank_bus_i = 0, bank_rd_o;
  logic        bank_lit_we_i = 0, bank_bus_we_i = 0, mov_en_i = 0, mov_dst_sel_i = 0;
  logic [11:0] mov_src_i = 0, mov_dst_i = 0, addr_o;
  logic        sfr_o, dest_f_o, access_o;
  int n_chk = 0, n_fail = 0;
  logic [3:0]  m_bank = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  bank_addr_gen u_dut (.*);

  function automatic logic [11:0] exp_addr(logic a, logic [7:0] off, logic [3:0] bk,
      logic men, logic dsel, logic [11:0] s, logic [11:0] d);
    if (men) return dsel ? d : s;
    if (a) return {bk, off};
    return off < 8'h80 ? {4'h0, off} : {4'hF, off};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, check combinational outputs 1 ns later
  task automatic step(logic [1:0] op, logic [7:0] off, logic men, logic dsel,
      logic [11:0] s, logic [11:0] d, string req);
    logic [11:0] e;
    @(negedge clk_i);
    op_lo_i = op; offset_i = off; mov_en_i = men; mov_dst_sel_i = dsel;
    mov_src_i = s; mov_dst_i = d;
    #1;
    e = exp_addr(op[0], off, m_bank, men, dsel, s, d);
    chk(req, 32'(addr_o), 32'(e));
    chk("R10", 32'(sfr_o), 32'(e >= 12'hF80));
    chk("R11", {30'd0, dest_f_o, access_o}, {30'd0, op});
    chk("R8", 32'(bank_rd_o), {28'd0, m_bank});
  endtask

  task automatic wr(logic lwe, logic [7:0] lv, logic bwe, logic [7:0] bv);
    @(negedge clk_i);
    bank_lit_we_i = lwe; bank_lit_i = lv; bank_bus_we_i = bwe; bank_bus_i = bv;
    @(posedge clk_i);
    if (lwe) m_bank = lv[3:0];
    else if (bwe) m_bank = bv[3:0];
    @(negedge clk_i);
    bank_lit_we_i = 0; bank_bus_we_i = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    #1;
    chk("R1", 32'(bank_rd_o), 32'd0);
    #20 rst_ni = 1;
    step(2'b01, 8'h3C, 0, 0, 0, 0, "R1");
    step(2'b00, 8'h7F, 0, 0, 0, 0, "R2");
    step(2'b10, 8'h00, 0, 0, 0, 0, "R2");
    step(2'b00, 8'h80, 0, 0, 0, 0, "R3");
    step(2'b10, 8'hFF, 0, 0, 0, 0, "R3");
    wr(1, 8'hA5, 0, 8'h00);
    step(2'b01, 8'h12, 0, 0, 0, 0, "R5");
    step(2'b00, 8'h12, 0, 0, 0, 0, "R2");
    wr(0, 8'h00, 1, 8'h3F);
    step(2'b11, 8'h7F, 0, 0, 0, 0, "R6");
    step(2'b01, 8'h80, 0, 0, 0, 0, "R4");
    wr(1, 8'hC2, 1, 8'h07);
    step(2'b01, 8'h44, 0, 0, 0, 0, "R7");
    wr(0, 8'hFF, 0, 8'hFF);
    step(2'b01, 8'h44, 0, 0, 0, 0, "R5");
    wr(1, 8'hF9, 0, 8'h00);
    step(2'b01, 8'h20, 0, 0, 0, 0, "R8");
    step(2'b00, 8'h20, 1, 0, 12'hF7F, 12'hF80, "R9");
    step(2'b01, 8'h20, 1, 1, 12'hF7F, 12'hF80, "R9");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[0] | r[1])
        wr(r[0], 8'($urandom), r[1], 8'($urandom));
      step(r[5:4], 8'($urandom), r[8] & r[9], r[10], 12'($urandom), 12'($urandom),
           r[0] & r[1] ? "R7" : "R4");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule